// File: doc/BRIEF.md
# Three-Stage In-Order Stalling Pipeline

This block is a small in-order integer processor core. It has three stages: fetch, decode and execute. Each cycle, fetch presents a program counter on an instruction-memory address port and captures the 32-bit word that comes back. Decode turns that word into a micro-operation. Execute reads the register file, computes the result and writes it back, all within the one stage. Execute takes a variable number of cycles that depends on the opcode. While a multi-cycle instruction occupies execute, fetch and decode hold their contents and the program counter does not move.

There are no branches, so the program counter only counts upward. Because every instruction reads and writes registers in the same stage, no dependency checking or forwarding is needed. A program is a count of instructions starting at address 0. When the program counter has reached that count and every stage is empty, the block raises `done`. Two counters, total cycles and retired instructions, allow IPC to be computed. A debug read port exposes any register so that a testbench can compare final state against a model.

Top module: `pipe3_core`

## Requirements
- R1: While reset is active, and right after it, all 16 registers read as zero, both counters are zero and `imem_addr` is zero.
- R2: The instruction format is: bits 31:24 opcode, bits 19:16 destination register, bits 11:8 left register, bits 3:0 right register, bits 7:0 an 8-bit immediate zero-extended to 32 bits. Opcodes with bit 0 set use the immediate as the right operand.
- R3: Opcode 0x00 writes the immediate to the destination. Opcodes 0x10 and 0x11 add. Opcodes 0x20 and 0x21 subtract right from left. Results wrap modulo 2^32.
- R4: Opcodes 0x30 and 0x31 write the low 32 bits of the unsigned product. Opcodes 0x40 and 0x41 write the unsigned floor quotient. A divisor of zero writes 0xFFFFFFFF.
- R5: Execute occupancy is 1 cycle for set, add, sub and unknown opcodes, 2 cycles for mul and 4 cycles for div. A program therefore completes in 3 plus the sum of its latencies cycles.
- R6: While execute is busy, `imem_addr` holds its value. Otherwise it advances by one each cycle until it reaches `prog_len`.
- R7: An opcode outside the ten listed takes one execute cycle, retires and writes no register.
- R8: `done` is high exactly when `imem_addr` equals `prog_len` and all three stages are empty. With `prog_len` = 0, it is high straight out of reset.
- R9: `cycle_count` increments on every clock edge while `done` is low and then freezes. `retire_count` increments once per instruction that leaves execute.
- R10: `dbg_data` shows register `dbg_sel` combinationally.
- R11: Each instruction sees the results of all earlier instructions (sequential semantics), with no extra stall beyond execute latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_len | input | PC_W | Number of instructions in the program |
| imem_addr | output | PC_W | Instruction address (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dbg_sel | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Contents of register `dbg_sel` |
| done | output | 1 | Program finished and pipeline drained |
| cycle_count | output | CNT_W | Cycles counted since reset until done |
| retire_count | output | CNT_W | Instructions retired since reset |

## Verification
Instruction k's register write lands on the clock edge 3 + (sum of latencies of instructions 0..k) after reset release: one edge each for fetch and decode entry, one for entering execute, then its own occupancy. The address port reacts on the edge right after each fetch. For a leading div, the address therefore sits at 3 across three stalled edges and moves to 4 on the edge where the div retires. The bench drives inputs and reads results on the falling edge, so each value is seen half a cycle after the rising edge that produced it. Final register, cycle and retire values are read only once `done` is high, and they are compared against a sequential model of the program and a latency sum that the bench computes itself.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);
  localparam int LAT_W  = 3;

  typedef enum logic [2:0] {K_SET, K_ADD, K_SUB, K_MUL, K_DIV, K_NOP} op_kind_e;

  typedef struct packed {
    op_kind_e          kind;
    logic              imm_sel;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] lsrc;
    logic [RIDX_W-1:0] rsrc;
    logic [7:0]        imm;
    logic [LAT_W-1:0]  lat;
  } uop_t;

  // Field split and opcode classification of one instruction word.
  function automatic uop_t decode_word(input logic [31:0] w);
    uop_t u;
    u.dst     = w[16 +: RIDX_W];
    u.lsrc    = w[8 +: RIDX_W];
    u.rsrc    = w[0 +: RIDX_W];
    u.imm     = w[7:0];
    u.imm_sel = w[24];
    u.lat     = LAT_W'(1);
    u.kind    = K_NOP;
    case (w[31:24])
      8'h00:        begin u.kind = K_SET; u.imm_sel = 1'b1; end
      8'h10, 8'h11: u.kind = K_ADD;
      8'h20, 8'h21: u.kind = K_SUB;
      8'h30, 8'h31: begin u.kind = K_MUL; u.lat = LAT_W'(2); end
      8'h40, 8'h41: begin u.kind = K_DIV; u.lat = LAT_W'(4); end
      default:      u.kind = K_NOP;
    endcase
    return u;
  endfunction

  // Result of one operation on two operands.
  function automatic logic [XLEN-1:0] alu_eval(input op_kind_e k,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (k)
      K_SET:   return b;
      K_ADD:   return a + b;
      K_SUB:   return a - b;
      K_MUL:   return a * b;
      K_DIV:   return (b == '0) ? '1 : a / b;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pipe3_fetch.sv
module pipe3_fetch #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic [PC_W-1:0] prog_len,
  input  logic [31:0]     imem_data,
  output logic [PC_W-1:0] pc,
  output logic            f_valid,
  output logic [31:0]     f_instr
);
  logic more;
  assign more = (pc < prog_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      f_valid <= 1'b0;
      f_instr <= '0;
    end else if (!stall) begin
      f_valid <= more;
      if (more) begin
        f_instr <= imem_data;
        pc      <= pc + PC_W'(1);
      end
    end
  end

  // R6
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc));

  // R8
  pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= prog_len);
endmodule

// File: rtl/pipe3_decode.sv
module pipe3_decode
  import pipe3_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic        f_valid,
  input  logic [31:0] f_instr,
  output logic        d_valid,
  output uop_t        d_uop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_uop   <= '0;
    end else if (!stall) begin
      d_valid <= f_valid;
      if (f_valid) d_uop <= decode_word(f_instr);
    end
  end

  // R6
  decode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(d_uop) && $stable(d_valid)));
endmodule

// File: rtl/pipe3_exec.sv
module pipe3_exec
  import pipe3_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  uop_t              d_uop,
  input  logic [RIDX_W-1:0] dbg_sel,
  output logic [XLEN-1:0]   dbg_data,
  output logic              stall,
  output logic              e_valid,
  output logic [CNT_W-1:0]  retire_count
);
  uop_t             e_uop;
  logic [LAT_W-1:0] e_cnt;
  logic             e_last;
  logic             wb_en;
  logic [XLEN-1:0]  regs [NREG];
  logic [XLEN-1:0]  op_a, op_b, result;

  assign e_last = e_valid && (e_cnt == e_uop.lat - LAT_W'(1));
  assign stall  = e_valid && !e_last;
  assign wb_en  = e_last && (e_uop.kind != K_NOP);

  assign op_a   = regs[e_uop.lsrc];
  assign op_b   = e_uop.imm_sel ? {{(XLEN-8){1'b0}}, e_uop.imm} : regs[e_uop.rsrc];
  assign result = alu_eval(e_uop.kind, op_a, op_b);
  assign dbg_data = regs[dbg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 1'b0;
      e_uop   <= '0;
      e_cnt   <= '0;
    end else if (!stall) begin
      e_valid <= d_valid;
      e_uop   <= d_uop;
      e_cnt   <= '0;
    end else begin
      e_cnt   <= e_cnt + LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) retire_count <= '0;
    else if (e_last) retire_count <= retire_count + CNT_W'(1);
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[i] <= '0;
        else if (wb_en && (e_uop.dst == RIDX_W'(i))) regs[i] <= result;
      end
    end
  endgenerate

  // R5
  lat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_valid |-> (e_cnt < e_uop.lat));
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   prog_len,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [31:0]       imem_data,
  input  logic [RIDX_W-1:0] dbg_sel,
  output logic [XLEN-1:0]   dbg_data,
  output logic              done,
  output logic [CNT_W-1:0]  cycle_count,
  output logic [CNT_W-1:0]  retire_count
);
  logic        stall, f_valid, d_valid, e_valid;
  logic [31:0] f_instr;
  uop_t        d_uop;

  pipe3_fetch #(.PC_W(PC_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .stall(stall), .prog_len(prog_len),
    .imem_data(imem_data), .pc(imem_addr), .f_valid(f_valid), .f_instr(f_instr)
  );

  pipe3_decode u_decode (
    .clk(clk), .rst_n(rst_n), .stall(stall), .f_valid(f_valid),
    .f_instr(f_instr), .d_valid(d_valid), .d_uop(d_uop)
  );

  pipe3_exec #(.CNT_W(CNT_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_uop(d_uop),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .stall(stall),
    .e_valid(e_valid), .retire_count(retire_count)
  );

  assign done = (imem_addr == prog_len) && !f_valid && !d_valid && !e_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cycle_count <= '0;
    else if (!done) cycle_count <= cycle_count + CNT_W'(1);
  end

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(cycle_count) && $stable(retire_count)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall);
endmodule

// File: tb/sim_pipe3_core.sv
module sim_pipe3_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  prog_len = '0;
  logic [7:0]  imem_addr;
  logic [31:0] imem_data;
  logic [3:0]  dbg_sel = '0;
  logic [31:0] dbg_data;
  logic        done;
  logic [31:0] cycle_count, retire_count;
  logic [31:0] imem [256];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign imem_data = imem[imem_addr];

  pipe3_core u0 (
    .clk(clk), .rst_n(rst_n), .prog_len(prog_len), .imem_addr(imem_addr),
    .imem_data(imem_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .done(done), .cycle_count(cycle_count), .retire_count(retire_count)
  );

  // Main program: each word is opcode, dest, left, right/immediate.
  localparam logic [31:0] PROG [16] = '{
    32'h00010007, 32'h00020003, 32'h10030102, 32'h20040201,
    32'h30050102, 32'h41060504, 32'h110703FA, 32'h21080705,
    32'h310908FF, 32'h400A0100, 32'h550B0102, 32'h000F00FF,
    32'h400C0902, 32'h300D0404, 32'h100E0F0F, 32'h00000001
  };

  function automatic int ref_lat(input logic [7:0] op);
    if (op[7:4] == 4'h3) return 2;
    if (op[7:4] == 4'h4) return 4;
    return 1;
  endfunction

  function automatic bit ref_known(input logic [7:0] op);
    return (op[7:4] <= 4'h4) && (op[3:1] == 3'b000) && (op != 8'h01);
  endfunction

  function automatic logic [31:0] ref_calc(input logic [7:0] op,
                                           input logic [31:0] l,
                                           input logic [31:0] r);
    logic [63:0] p;
    case (op[7:4])
      4'h0: return r;
      4'h1: return l + r;
      4'h2: return l + (~r + 32'd1);
      4'h3: begin p = {32'd0, l} * {32'd0, r}; return p[31:0]; end
      default: begin
        if (r == 32'd0) return 32'hFFFF_FFFF;
        return l / r;
      end
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [7:0] len);
    @(negedge clk);
    rst_n = 1'b0;
    prog_len = len;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
  endtask

  task automatic read_reg(input int idx, output logic [31:0] v);
    dbg_sel = idx[3:0];
    #1;
    v = dbg_data;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R8 actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] model [16];
    logic [31:0] v, rv, hold;
    int lat_sum;
    for (int i = 0; i < 256; i++) imem[i] = 32'h0;

    // ---- Main program walked from the table ----
    for (int i = 0; i < 16; i++) imem[i] = PROG[i];
    for (int i = 0; i < 16; i++) model[i] = 32'd0;
    lat_sum = 0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] op;
      op = PROG[i][31:24];
      lat_sum += ref_lat(op);
      if (ref_known(op)) begin
        rv = PROG[i][24] || (op == 8'h00) ? {24'd0, PROG[i][7:0]} : model[PROG[i][3:0]];
        model[PROG[i][19:16]] = ref_calc(op, model[PROG[i][11:8]], rv);
      end
    end
    apply_reset(8'd16);
    wait_done();
    check32("R8 done after main program", {31'd0, done}, 32'd1);
    // R5: total cycles = 3 + latency sum
    check32("R5 total cycles", cycle_count, 32'(3 + lat_sum));
    check32("R9 retired count", retire_count, 32'd16);
    for (int i = 0; i < 16; i++) begin
      read_reg(i, v);
      // R2 R3 R4 R10 R11 final register state
      check32($sformatf("R3,R4,R10,R11 reg %0d", i), v, model[i]);
    end
    read_reg(11, v);
    check32("R7 unknown opcode leaves dest untouched", v, 32'd0);
    read_reg(10, v);
    check32("R4 divide by zero", v, 32'hFFFF_FFFF);
    hold = cycle_count;
    repeat (5) @(negedge clk);
    check32("R9 cycle count frozen after done", cycle_count, hold);

    // ---- Stall: leading div holds the address port ----
    imem[0] = 32'h41010002;
    imem[1] = 32'h00020009;
    imem[2] = 32'h00030008;
    imem[3] = 32'h00040007;
    apply_reset(8'd4);
    for (int e = 1; e <= 7; e++) begin
      @(negedge clk);
      if (e == 1) check32("R6 fetch advances edge1", 32'(imem_addr), 32'd1);
      if (e == 3) check32("R6 fetch advances edge3", 32'(imem_addr), 32'd3);
      if (e >= 4 && e <= 6) check32($sformatf("R6 address held edge%0d", e), 32'(imem_addr), 32'd3);
      if (e == 6) check32("R5 div not retired before 4 cycles", retire_count, 32'd0);
      if (e == 7) begin
        check32("R6 address resumes after div", 32'(imem_addr), 32'd4);
        check32("R5 div retires on 4th execute cycle", retire_count, 32'd1);
      end
    end
    wait_done();
    check32("R5 stall program cycles", cycle_count, 32'd10);
    read_reg(2, v);
    check32("R3 set value before reset", v, 32'd9);

    // ---- Reset state ----
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    read_reg(2, v);
    check32("R1 register cleared", v, 32'd0);
    check32("R1 retire count zero", retire_count, 32'd0);
    check32("R1 cycle count zero", cycle_count, 32'd0);
    check32("R1 address zero", 32'(imem_addr), 32'd0);

    // ---- Zero-length program ----
    apply_reset(8'd0);
    #1;
    check32("R8 done at once for empty program", {31'd0, done}, 32'd1);
    repeat (3) @(negedge clk);
    check32("R9 no cycles counted for empty program", cycle_count, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule